// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small, fully associative translation buffer that system software fills and maintains. On each lookup it takes a 32-bit virtual address, the address-space identifier of the running process and a store flag. It compares the page number against every slot at once. One cycle later it returns a hit flag, the physical address, the cache-control bits and the dirty bit. The upper 20 address bits form the virtual page number and the low 12 bits are the page offset, which passes through untranslated.

A command port lets privileged software manage the contents. It can probe for a matching entry, read or write a slot by index, write a slot chosen by a free-running replacement counter, and invalidate every slot at once. A wired count keeps the low-numbered slots out of reach of the random write. Translations tagged with different identifiers can therefore stay resident across context switches without flushing. An entry marked global matches any identifier.

Top module: `asid_tlb`

## Requirements
- R1: An entry hits only when its valid bit is set, its page number equals vaddr[31:12], and either its identifier equals the lookup identifier or its global bit is set. Otherwise the lookup misses.
- R2: Lookup results are registered and appear on the clock edge that samples `lk_valid`. On a hit, `rsp_paddr` is {frame, vaddr[11:0]}. On a miss, or when no lookup is issued, the hit flag, fault flag and physical address are zero.
- R3: Two entries with the same page number and different identifiers coexist, and each lookup selects the frame tagged with its own identifier.
- R4: A store lookup (`lk_store`=1) that hits an entry whose dirty bit is 0 raises `rsp_modfault` and leaves `rsp_hit` low. A load, or a store to an entry whose dirty bit is 1, gives a plain hit.
- R5: Probe (`cmd_op`=1) searches with `cmd_vpn`/`cmd_asid` under the rule of R1 and reports the lowest matching index with `res_miss`=0. If nothing matches it reports `res_miss`=1 and `res_index`=0.
- R6: Read (`cmd_op`=2) returns every field of the slot at `cmd_index` on the `res_*` outputs one cycle later.
- R7: Indexed write (`cmd_op`=3) stores the `cmd_*` fields into slot `cmd_index` and reports that index on `res_index`.
- R8: Random write (`cmd_op`=4) stores into a slot between `wired_count` and ENTRIES-1 inclusive and reports that slot on `res_index`. Slots below `wired_count` are left unchanged.
- R9: Flush (`cmd_op`=5) clears the valid bit of every slot, so later lookups and probes miss.
- R10: A lookup issued in the same cycle as a command observes the contents as they were before that command.
- R11: After reset every slot is invalid and all response outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_asid | input | 8 | Identifier of the current address space |
| lk_store | input | 1 | Lookup is for a store |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Clean translation hit |
| rsp_modfault | output | 1 | Store hit a page that is not writable |
| rsp_paddr | output | 36 | Translated physical address |
| rsp_cache | output | 3 | Cache-control bits of the hit entry |
| rsp_dirty | output | 1 | Dirty bit of the hit entry |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (1 probe, 2 read, 3 write, 4 random write, 5 flush) |
| cmd_index | input | 5 | Slot for read and indexed write |
| cmd_vpn | input | 20 | Page number for probe and write |
| cmd_asid | input | 8 | Identifier for probe and write |
| cmd_pfn | input | 24 | Frame number to write |
| cmd_global | input | 1 | Global bit to write |
| cmd_cache | input | 3 | Cache-control bits to write |
| cmd_dirty | input | 1 | Dirty (write-enable) bit to write |
| cmd_entry_valid | input | 1 | Valid bit to write |
| wired_count | input | 5 | Number of low slots protected from random write |
| res_valid | output | 1 | Command result present |
| res_miss | output | 1 | Probe found nothing |
| res_index | output | 5 | Probed, read or written slot |
| res_vpn | output | 20 | Read-back page number |
| res_asid | output | 8 | Read-back identifier |
| res_pfn | output | 24 | Read-back frame number |
| res_global | output | 1 | Read-back global bit |
| res_cache | output | 3 | Read-back cache-control bits |
| res_dirty | output | 1 | Read-back dirty bit |
| res_entry_valid | output | 1 | Read-back valid bit |

## Verification
A translation request and a software command can fall in the same cycle. The case that matters is an indexed write or a flush that lands on the very entry being looked up. The bench drives both strobes together, first rewriting the frame of a live entry and later flushing the buffer. It requires the lookup issued alongside to return the old frame, and a hit in the flush case, and it requires the next lookup to show the new frame or a miss.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = 24;
  localparam int ASID_W = 8;
  localparam int CCH_W  = 3;
  localparam int PA_W   = PFN_W + OFF_W;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_PROBE = 3'd1,
    OP_READ  = 3'd2,
    OP_WRITE = 3'd3,
    OP_WRAND = 3'd4,
    OP_FLUSH = 3'd5
  } tlb_op_e;

  typedef struct packed {
    logic              valid;
    logic              glob;
    logic              dirty;
    logic [CCH_W-1:0]  cache;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
  } tlb_entry_t;

  // Match rule shared by lookup and probe
  function automatic logic entry_hits(tlb_entry_t e, logic [VPN_W-1:0] vpn,
                                      logic [ASID_W-1:0] asid);
    return e.valid && (e.vpn == vpn) && (e.glob || (e.asid == asid));
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  tlb_entry_t        ent [ENTRIES],
  input  logic [VPN_W-1:0]  vpn,
  input  logic [ASID_W-1:0] asid,
  output logic              any,
  output logic [IDX_W-1:0]  idx,
  output logic [ENTRIES-1:0] hit_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = entry_hits(ent[g], vpn, asid);
  end

  // Lowest matching slot wins
  always_comb begin
    any = |hit_vec;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] wired,
  output logic [IDX_W-1:0] victim
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

  logic [IDX_W-1:0] cnt;

  function automatic logic [IDX_W-1:0] fold(logic [IDX_W-1:0] c, logic [IDX_W-1:0] w);
    return (c < w) ? TOP : c;
  endfunction

  // Counts down each cycle, wrapping from the wired boundary to the top slot
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= TOP;
    else if (cnt <= wired) cnt <= TOP;
    else                 cnt <= cnt - 1'b1;
  end

  assign victim = fold(cnt, wired);
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic              lk_store,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_modfault,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [CCH_W-1:0]  rsp_cache,
  output logic              rsp_dirty,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_index,
  input  logic [VPN_W-1:0]  cmd_vpn,
  input  logic [ASID_W-1:0] cmd_asid,
  input  logic [PFN_W-1:0]  cmd_pfn,
  input  logic              cmd_global,
  input  logic [CCH_W-1:0]  cmd_cache,
  input  logic              cmd_dirty,
  input  logic              cmd_entry_valid,
  input  logic [IDX_W-1:0]  wired_count,
  output logic              res_valid,
  output logic              res_miss,
  output logic [IDX_W-1:0]  res_index,
  output logic [VPN_W-1:0]  res_vpn,
  output logic [ASID_W-1:0] res_asid,
  output logic [PFN_W-1:0]  res_pfn,
  output logic              res_global,
  output logic [CCH_W-1:0]  res_cache,
  output logic              res_dirty,
  output logic              res_entry_valid
);
  tlb_entry_t ent [ENTRIES];
  tlb_entry_t new_entry;
  tlb_entry_t sel;
  tlb_entry_t res_q;
  tlb_op_e    op;

  logic [ENTRIES-1:0] valid_vec;
  logic [ENTRIES-1:0] lk_vec;
  logic [ENTRIES-1:0] pr_vec;
  logic               lk_any, pr_any;
  logic [IDX_W-1:0]   lk_idx, pr_idx;
  logic [IDX_W-1:0]   rnd_victim;
  logic [IDX_W-1:0]   wr_idx;
  logic               do_write, do_flush;
  logic               lk_fault, lk_clean;

  assign op       = tlb_op_e'(cmd_op);
  assign do_write = cmd_valid && (op == OP_WRITE || op == OP_WRAND);
  assign do_flush = cmd_valid && (op == OP_FLUSH);
  assign wr_idx   = (op == OP_WRAND) ? rnd_victim : cmd_index;

  assign new_entry = '{valid: cmd_entry_valid, glob: cmd_global, dirty: cmd_dirty,
                       cache: cmd_cache, asid: cmd_asid, vpn: cmd_vpn, pfn: cmd_pfn};

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign valid_vec[g] = ent[g].valid;
  end

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .wired(wired_count), .victim(rnd_victim)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_lk_match (
    .ent(ent), .vpn(lk_vaddr[VA_W-1:OFF_W]), .asid(lk_asid),
    .any(lk_any), .idx(lk_idx), .hit_vec(lk_vec)
  );

  tlb_match #(.ENTRIES(ENTRIES)) u_pr_match (
    .ent(ent), .vpn(cmd_vpn), .asid(cmd_asid),
    .any(pr_any), .idx(pr_idx), .hit_vec(pr_vec)
  );

  // Storage: only software commands change it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ent[i] <= '0;
    end else if (do_flush) begin
      for (int i = 0; i < ENTRIES; i++) ent[i].valid <= 1'b0;
    end else if (do_write) begin
      ent[wr_idx] <= new_entry;
    end
  end

  // Lookup path reads pre-command contents
  assign sel      = ent[lk_idx];
  assign lk_fault = lk_valid && lk_any && lk_store && !sel.dirty;
  assign lk_clean = lk_valid && lk_any && !lk_fault;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_modfault <= 1'b0;
      rsp_paddr    <= '0;
      rsp_cache    <= '0;
      rsp_dirty    <= 1'b0;
    end else begin
      rsp_valid    <= lk_valid;
      rsp_hit      <= lk_clean;
      rsp_modfault <= lk_fault;
      rsp_paddr    <= lk_clean ? {sel.pfn, lk_vaddr[OFF_W-1:0]} : '0;
      rsp_cache    <= lk_clean ? sel.cache : '0;
      rsp_dirty    <= lk_clean ? sel.dirty : 1'b0;
    end
  end

  // Command results
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_miss  <= 1'b0;
      res_index <= '0;
      res_q     <= '0;
    end else begin
      res_valid <= cmd_valid;
      res_miss  <= cmd_valid && (op == OP_PROBE) && !pr_any;
      res_q     <= (cmd_valid && op == OP_READ) ? ent[cmd_index] : '0;
      if (!cmd_valid)                          res_index <= '0;
      else if (op == OP_PROBE)                 res_index <= pr_any ? pr_idx : '0;
      else if (op == OP_READ)                  res_index <= cmd_index;
      else if (op == OP_WRITE || op == OP_WRAND) res_index <= wr_idx;
      else                                     res_index <= '0;
    end
  end

  assign res_vpn         = res_q.vpn;
  assign res_asid        = res_q.asid;
  assign res_pfn         = res_q.pfn;
  assign res_global      = res_q.glob;
  assign res_cache       = res_q.cache;
  assign res_dirty       = res_q.dirty;
  assign res_entry_valid = res_q.valid;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_store,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_modfault,
  input logic [PA_W-1:0]    rsp_paddr,
  input logic               res_valid,
  input logic               res_miss,
  input logic [IDX_W-1:0]   res_index,
  input logic [IDX_W-1:0]   wired_count,
  input logic [IDX_W-1:0]   rnd_victim,
  input logic [ENTRIES-1:0] valid_vec,
  input logic               do_flush
);
  assert_fault_not_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_modfault));

  assert_fault_from_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_modfault |-> $past(lk_store && lk_valid));

  assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0]));

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> (!rsp_valid && !rsp_hit && !rsp_modfault));

  assert_victim_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_victim >= wired_count);

  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_flush |=> valid_vec == '0);

  assert_probe_miss_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_miss) |-> res_index == '0);
endmodule

bind asid_tlb tlb_checker #(.ENTRIES(ENTRIES)) u_chk (.*);

// File: tb/sim_asid_tlb.sv
`timescale 1ns/1ps
module sim_asid_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic [7:0]  lk_asid = '0;
  logic        lk_store = 1'b0;
  logic        rsp_valid, rsp_hit, rsp_modfault, rsp_dirty;
  logic [35:0] rsp_paddr;
  logic [2:0]  rsp_cache;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [4:0]  cmd_index = '0;
  logic [19:0] cmd_vpn = '0;
  logic [7:0]  cmd_asid = '0;
  logic [23:0] cmd_pfn = '0;
  logic        cmd_global = 1'b0;
  logic [2:0]  cmd_cache = '0;
  logic        cmd_dirty = 1'b0;
  logic        cmd_entry_valid = 1'b0;
  logic [4:0]  wired_count = '0;
  logic        res_valid, res_miss, res_global, res_dirty, res_entry_valid;
  logic [4:0]  res_index;
  logic [19:0] res_vpn;
  logic [7:0]  res_asid;
  logic [23:0] res_pfn;
  logic [2:0]  res_cache;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  asid_tlb u0 (.*);

  task automatic chk_eq(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    lk_valid  = 1'b0;
    cmd_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cmd(input logic [2:0] op, input logic [4:0] idx,
                         input logic [19:0] vpn, input logic [7:0] asid,
                         input logic [23:0] pfn, input logic g,
                         input logic [2:0] cch, input logic d);
    cmd_valid = 1'b1; cmd_op = op; cmd_index = idx; cmd_vpn = vpn;
    cmd_asid = asid; cmd_pfn = pfn; cmd_global = g; cmd_cache = cch;
    cmd_dirty = d; cmd_entry_valid = 1'b1;
  endtask

  task automatic set_lk(input logic [31:0] va, input logic [7:0] asid, input logic st);
    lk_valid = 1'b1; lk_vaddr = va; lk_asid = asid; lk_store = st;
  endtask

  task automatic wr(input logic [4:0] idx, input logic [19:0] vpn, input logic [7:0] asid,
                    input logic [23:0] pfn, input logic g, input logic [2:0] cch,
                    input logic d);
    set_cmd(3'd3, idx, vpn, asid, pfn, g, cch, d);
    step();
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic st);
    set_lk(va, asid, st);
    step();
  endtask

  task automatic t_reset();
    chk_eq("R11", "rsp_hit after reset", rsp_hit, 0);
    chk_eq("R11", "res_valid after reset", res_valid, 0);
    look(32'h1234_5678, 8'd7, 1'b0);
    chk_eq("R11", "lookup after reset misses", rsp_hit, 0);
    chk_eq("R2", "miss paddr zero", rsp_paddr, 0);
    set_cmd(3'd2, 5'd5, '0, '0, '0, 0, 0, 0); step();
    chk_eq("R11", "slot 5 invalid after reset", res_entry_valid, 0);
  endtask

  task automatic t_basic();
    wr(5'd3, 20'h12345, 8'd7, 24'h0ABCDE, 1'b0, 3'd2, 1'b1);
    chk_eq("R7", "write reports index", res_index, 3);
    chk_eq("R2", "no lookup means no rsp_valid", rsp_valid, 0);
    look(32'h1234_5678, 8'd7, 1'b0);
    chk_eq("R1", "hit same asid", rsp_hit, 1);
    chk_eq("R2", "paddr", rsp_paddr, 36'h0ABCDE678);
    chk_eq("R2", "cache bits", rsp_cache, 2);
    look(32'h1234_5678, 8'd8, 1'b0);
    chk_eq("R1", "other asid misses", rsp_hit, 0);
    look(32'h1234_6678, 8'd7, 1'b0);
    chk_eq("R1", "other page misses", rsp_hit, 0);
    wr(5'd4, 20'h00400, 8'd1, 24'h000777, 1'b1, 3'd0, 1'b1);
    look(32'h0040_0ABC, 8'h55, 1'b0);
    chk_eq("R1", "global ignores asid", rsp_paddr, 36'h000777ABC);
    set_cmd(3'd3, 5'd6, 20'h00500, 8'd1, 24'h1, 1'b1, 3'd0, 1'b1);
    cmd_entry_valid = 1'b0; step();
    look(32'h0050_0000, 8'd1, 1'b0);
    chk_eq("R1", "invalid slot misses", rsp_hit, 0);
  endtask

  task automatic t_coexist();
    wr(5'd10, 20'h00010, 8'd1, 24'd100, 1'b0, 3'd1, 1'b1);
    wr(5'd11, 20'h00010, 8'd2, 24'd170, 1'b0, 3'd1, 1'b1);
    look(32'h0001_0004, 8'd1, 1'b0);
    chk_eq("R3", "asid1 frame", rsp_paddr, {24'd100, 12'h004});
    look(32'h0001_0004, 8'd2, 1'b0);
    chk_eq("R3", "asid2 frame", rsp_paddr, {24'd170, 12'h004});
  endtask

  task automatic t_modfault();
    wr(5'd12, 20'h00020, 8'd3, 24'h000042, 1'b0, 3'd0, 1'b0);
    look(32'h0002_0010, 8'd3, 1'b1);
    chk_eq("R4", "store to clean page faults", rsp_modfault, 1);
    chk_eq("R4", "store to clean page no hit", rsp_hit, 0);
    look(32'h0002_0010, 8'd3, 1'b0);
    chk_eq("R4", "load to clean page hits", rsp_hit, 1);
    chk_eq("R4", "load no fault", rsp_modfault, 0);
    look(32'h1234_5000, 8'd7, 1'b1);
    chk_eq("R4", "store to dirty page hits", rsp_hit, 1);
    chk_eq("R4", "store to dirty page no fault", rsp_modfault, 0);
  endtask

  task automatic t_probe_read();
    wr(5'd20, 20'h00030, 8'd3, 24'h000020, 1'b0, 3'd0, 1'b1);
    wr(5'd15, 20'h00030, 8'd3, 24'h000015, 1'b0, 3'd0, 1'b1);
    set_cmd(3'd1, 5'd0, 20'h00030, 8'd3, '0, 0, 0, 0); step();
    chk_eq("R5", "probe lowest index", res_index, 15);
    chk_eq("R5", "probe hit flag", res_miss, 0);
    set_cmd(3'd1, 5'd9, 20'h00400, 8'hEE, '0, 0, 0, 0); step();
    chk_eq("R5", "probe global entry", res_index, 4);
    set_cmd(3'd1, 5'd9, 20'h00999, 8'd3, '0, 0, 0, 0); step();
    chk_eq("R5", "probe miss flag", res_miss, 1);
    chk_eq("R5", "probe miss index", res_index, 0);
    set_cmd(3'd2, 5'd10, '0, '0, '0, 0, 0, 0); step();
    chk_eq("R6", "read vpn", res_vpn, 20'h00010);
    chk_eq("R6", "read asid", res_asid, 1);
    chk_eq("R6", "read pfn", res_pfn, 100);
    chk_eq("R6", "read cache", res_cache, 1);
    chk_eq("R6", "read flags", {res_global, res_dirty, res_entry_valid}, 3'b011);
    chk_eq("R6", "read index", res_index, 10);
  endtask

  task automatic t_random();
    wired_count = 5'd8;
    for (int i = 0; i < 8; i++)
      wr(5'(i), 20'h00100 + 20'(i), 8'd9, 24'h000500 + 24'(i), 1'b0, 3'd0, 1'b1);
    for (int k = 0; k < 20; k++) begin
      set_cmd(3'd4, 5'd0, 20'h00200 + 20'(k), 8'd9, 24'h000600 + 24'(k), 1'b0, 3'd0, 1'b1);
      step();
      n_chk++;
      if (res_index < 5'd8) begin
        n_fail++;
        $display("FAIL R8 random slot actual=%0d expected>=8", res_index);
      end
      look({12'h002, 8'(k), 12'h0}, 8'd9, 1'b0);
      chk_eq("R8", "random-written entry hits", rsp_paddr, {24'h000600 + 24'(k), 12'h0});
    end
    for (int i = 0; i < 8; i++) begin
      set_cmd(3'd2, 5'(i), '0, '0, '0, 0, 0, 0); step();
      chk_eq("R8", "wired slot kept", {res_entry_valid, res_vpn},
             {1'b1, 20'h00100 + 20'(i)});
    end
  endtask

  task automatic t_concurrent();
    wr(5'd25, 20'h00040, 8'd1, 24'h000111, 1'b0, 3'd0, 1'b1);
    set_lk(32'h0004_0000, 8'd1, 1'b0);
    set_cmd(3'd3, 5'd25, 20'h00040, 8'd1, 24'h000222, 1'b0, 3'd0, 1'b1);
    step();
    chk_eq("R10", "lookup sees old frame", rsp_paddr, 36'h000111000);
    look(32'h0004_0000, 8'd1, 1'b0);
    chk_eq("R7", "next lookup sees new frame", rsp_paddr, 36'h000222000);
    set_lk(32'h0004_0000, 8'd1, 1'b0);
    set_cmd(3'd5, 5'd0, '0, '0, '0, 0, 0, 0);
    step();
    chk_eq("R10", "lookup beside flush still hits", rsp_hit, 1);
    look(32'h0004_0000, 8'd1, 1'b0);
    chk_eq("R9", "after flush miss", rsp_hit, 0);
    look(32'h0040_0000, 8'd1, 1'b0);
    chk_eq("R9", "global entry flushed", rsp_hit, 0);
    set_cmd(3'd2, 5'd0, '0, '0, '0, 0, 0, 0); step();
    chk_eq("R9", "wired slot invalid after flush", res_entry_valid, 0);
    set_cmd(3'd1, 5'd0, 20'h00010, 8'd1, '0, 0, 0, 0); step();
    chk_eq("R9", "probe misses after flush", res_miss, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_coexist();
    t_modfault();
    t_probe_read();
    t_random();
    t_concurrent();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule